// File: doc/BRIEF.md
# Bus Master Transfer Sequencer

This block turns transfer requests from a cached processor core into cycle-by-cycle activity on a shared, multi-master system bus. The core hands over one request at a time: a request kind, a start address and, for the kinds whose length the core chooses, a word count. The block then produces the bus-side signals. These are a 2-bit transfer-type code, the address, a write flag, a look-ahead address strobe, a 2-bit burst-length hint and a "more words" flag for noncached load multiples.

The block never uses the nonsequential type code. Every access, whether a single word or a burst, begins with one address-only cycle that carries the strobe and is then followed by sequential cycles. A memory controller can therefore decode the address early and commit only when the sequential cycles arrive. It can also tell a real idle cycle from the opening cycle of a transfer by looking at the strobe.

The burst hint and the write flag together classify each access for the system. Bus grant and the slave's wait response are honoured on every cycle. If grant is lost partway through a burst, the block falls back to address-only cycles. Once grant returns, it resumes at the unfinished word with a fresh opening cycle.

Top module: `bus_xfer_seq`

## Requirements
- R1: `bus_trans` is 2'b11 (sequential) in a cycle where the block owns a sequential transfer and `bus_grant` is high, and 2'b00 (address-only) in every other cycle. The code 2'b10 (nonsequential) is never driven.
- R2: `bus_astrobe` is high only in the opening address-only cycle of an accepted request, and only while `bus_grant` is high. In idle cycles it stays low, whatever the grant does.
- R3: If `bus_grant` is high at the clock edge that ends a strobed cycle, the next cycle is sequential and carries the first outstanding word's address. Otherwise the block stays in opening cycles.
- R4: Kind codes on `req_kind` set `bus_burst` / `bus_write` as follows: 0 noncached read or load multiple 00/0; 1 nonbufferable store 00/1; 2 bufferable store 11/1; 3 table walk 11/0; 4 linefill 10/0; 5 short eviction 01/1; 6 long eviction 10/1; 7 behaves as 0.
- R5: The number of words is `req_len` for kinds 0, 1, 2 and 7, with a value of 0 taken as one word. Kind 3 moves 1 word, kind 4 moves FILL_WORDS (8), kind 5 moves EVICT_SHORT (4) and kind 6 moves EVICT_LONG (8).
- R6: `bus_burst` and `bus_write` take their new values in the first cycle after acceptance, which is the strobe cycle. They then hold until the next request is accepted, including after the transfer completes.
- R7: `bus_more` is high in a sequential cycle of a kind 0 or kind 7 transfer when further words remain, and low on its final word. It is low in all other cycles.
- R8: The first word address is `req_addr` with its two low bits cleared. Each completed word advances the address by 4 bytes.
- R9: A sequential cycle with `bus_wait` high completes nothing. The address, the type and the outstanding word count are unchanged in the next cycle.
- R10: If `bus_grant` is low in a sequential-phase cycle, that word does not complete and the block drives address-only cycles. When grant returns, it opens again with a strobed cycle at the same address.
- R11: `req_ready` is high exactly when no transfer is outstanding, and a request is accepted at an edge where `req_valid` and `req_ready` are both high. `req_done` is high in the cycle whose clock edge completes the final word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Core offers a request |
| req_kind | input | 3 | Request kind code (see R4) |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Word count for caller-sized kinds |
| req_ready | output | 1 | No transfer outstanding; request can be taken |
| req_done | output | 1 | Final word completes at this edge |
| bus_grant | input | 1 | Bus granted to this master |
| bus_wait | input | 1 | Slave extends the current sequential cycle |
| bus_trans | output | 2 | Transfer-type code |
| bus_addr | output | ADDR_W | Current word address |
| bus_write | output | 1 | Write direction |
| bus_astrobe | output | 1 | Look-ahead strobe on the opening cycle |
| bus_burst | output | 2 | Burst-length / class hint |
| bus_more | output | 1 | Further words wanted (noncached load multiple) |

## Verification
The assertions assume that `bus_grant` and `bus_wait` stay constant between clock edges, so the grant seen during a strobed cycle is the grant sampled at its closing edge. They also assume that `bus_wait` is meaningful only in granted sequential cycles. The stimulus drives every input on the falling edge. It holds each input through the whole following cycle, and it raises `bus_wait` only in cycles where it also grants the bus. Grant is removed for exactly two cycles per affected transfer. This exercises a lost grant both in the sequential phase and in the opening phase.

// File: rtl/bus_xfer_seq_pkg.sv
package bus_xfer_seq_pkg;

   typedef enum logic [2:0] {
      K_RD_NC   = 3'd0,
      K_WR_NB   = 3'd1,
      K_WR_BUF  = 3'd2,
      K_WALK    = 3'd3,
      K_FILL    = 3'd4,
      K_EVICT_S = 3'd5,
      K_EVICT_L = 3'd6,
      K_SPARE   = 3'd7
   } xfer_kind_e;

   typedef enum logic [1:0] {
      TT_ADDR = 2'b00,
      TT_NSEQ = 2'b10,
      TT_SEQ  = 2'b11
   } trans_e;

   typedef enum logic [1:0] {
      BH_NONE = 2'b00,
      BH_W4   = 2'b01,
      BH_W8   = 2'b10,
      BH_OPEN = 2'b11
   } burst_e;

   typedef enum logic [2:0] {
      LS_REQ   = 3'd0,
      LS_ONE   = 3'd1,
      LS_FILL  = 3'd2,
      LS_SHORT = 3'd3,
      LS_LONG  = 3'd4
   } len_sel_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_OPEN = 2'd1,
      ST_SEQ  = 2'd2
   } seq_state_e;

   typedef struct packed {
      burst_e   burst;
      logic     write;
      logic     more_en;
      len_sel_e sel;
   } xfer_class_t;

   function automatic xfer_class_t classify(xfer_kind_e k);
      xfer_class_t c;
      c = '{burst: BH_NONE, write: 1'b0, more_en: 1'b0, sel: LS_REQ};
      case (k)
         K_RD_NC:   c = '{burst: BH_NONE, write: 1'b0, more_en: 1'b1, sel: LS_REQ};
         K_WR_NB:   c = '{burst: BH_NONE, write: 1'b1, more_en: 1'b0, sel: LS_REQ};
         K_WR_BUF:  c = '{burst: BH_OPEN, write: 1'b1, more_en: 1'b0, sel: LS_REQ};
         K_WALK:    c = '{burst: BH_OPEN, write: 1'b0, more_en: 1'b0, sel: LS_ONE};
         K_FILL:    c = '{burst: BH_W8,   write: 1'b0, more_en: 1'b0, sel: LS_FILL};
         K_EVICT_S: c = '{burst: BH_W4,   write: 1'b1, more_en: 1'b0, sel: LS_SHORT};
         K_EVICT_L: c = '{burst: BH_W8,   write: 1'b1, more_en: 1'b0, sel: LS_LONG};
         default:   c = '{burst: BH_NONE, write: 1'b0, more_en: 1'b1, sel: LS_REQ};
      endcase
      return c;
   endfunction

endpackage

// File: rtl/bxs_classify.sv
module bxs_classify
   import bus_xfer_seq_pkg::*;
#(
   parameter int LEN_W       = 4,
   parameter int FILL_WORDS  = 8,
   parameter int EVICT_SHORT = 4,
   parameter int EVICT_LONG  = 8
) (
   input  logic [2:0]       kind_i,
   input  logic [LEN_W-1:0] len_i,
   output logic [1:0]       burst_o,
   output logic             write_o,
   output logic             more_en_o,
   output logic [LEN_W-1:0] words_o
);
   localparam logic [LEN_W-1:0] ONE_W   = LEN_W'(1);
   localparam logic [LEN_W-1:0] FILL_W  = LEN_W'(FILL_WORDS);
   localparam logic [LEN_W-1:0] SHORT_W = LEN_W'(EVICT_SHORT);
   localparam logic [LEN_W-1:0] LONG_W  = LEN_W'(EVICT_LONG);

   xfer_class_t cls;

   always_comb begin
      cls       = classify(xfer_kind_e'(kind_i));
      burst_o   = cls.burst;
      write_o   = cls.write;
      more_en_o = cls.more_en;
      case (cls.sel)
         LS_ONE:   words_o = ONE_W;
         LS_FILL:  words_o = FILL_W;
         LS_SHORT: words_o = SHORT_W;
         LS_LONG:  words_o = LONG_W;
         default:  words_o = (len_i == '0) ? ONE_W : len_i;
      endcase
   end
endmodule

// File: rtl/bxs_walker.sv
module bxs_walker #(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 4,
   parameter int WORD_BYTES = 4,
   parameter bit ALIGN_ADDR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [LEN_W-1:0]  words_i,
   input  logic              step_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              last_o
);
   localparam int LOW_BITS = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 0;
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

   logic [ADDR_W-1:0] start_addr;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  rem_q;

   generate
      if (ALIGN_ADDR && (LOW_BITS > 0)) begin : g_align
         assign start_addr = {addr_i[ADDR_W-1:LOW_BITS], {LOW_BITS{1'b0}}};
      end else begin : g_raw
         assign start_addr = addr_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         rem_q  <= '0;
      end else if (load_i) begin
         addr_q <= start_addr;
         rem_q  <= words_i;
      end else if (step_i) begin
         addr_q <= addr_q + STEP;
         rem_q  <= rem_q - LEN_W'(1);
      end
   end

   assign addr_o = addr_q;
   assign last_o = (rem_q == LEN_W'(1));
endmodule

// File: rtl/bxs_ctrl.sv
module bxs_ctrl
   import bus_xfer_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid_i,
   input  logic       grant_i,
   input  logic       wait_i,
   input  logic       last_i,
   output seq_state_e state_o,
   output logic       load_o,
   output logic       step_o
);
   seq_state_e st_q, st_d;

   always_comb begin
      load_o = (st_q == ST_IDLE) && req_valid_i;
      step_o = (st_q == ST_SEQ) && grant_i && !wait_i;
      st_d   = st_q;
      case (st_q)
         ST_IDLE: if (req_valid_i) st_d = ST_OPEN;
         ST_OPEN: if (grant_i) st_d = ST_SEQ;
         ST_SEQ: begin
            if (!grant_i)        st_d = ST_OPEN;
            else if (!wait_i && last_i) st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign state_o = st_q;
endmodule

// File: rtl/bus_xfer_seq.sv
module bus_xfer_seq
   import bus_xfer_seq_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int LEN_W       = 4,
   parameter int WORD_BYTES  = 4,
   parameter int FILL_WORDS  = 8,
   parameter int EVICT_SHORT = 4,
   parameter int EVICT_LONG  = 8,
   parameter bit ALIGN_ADDR  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   output logic              req_ready,
   output logic              req_done,
   input  logic              bus_grant,
   input  logic              bus_wait,
   output logic [1:0]        bus_trans,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_write,
   output logic              bus_astrobe,
   output logic [1:0]        bus_burst,
   output logic              bus_more
);
   localparam int MAX_WORDS = (1 << LEN_W) - 1;

   generate
      if (WORD_BYTES < 1 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_word
         $error("WORD_BYTES must be a power of two");
      end
      if (FILL_WORDS > MAX_WORDS || EVICT_LONG > MAX_WORDS || EVICT_SHORT > MAX_WORDS) begin : g_bad_len
         $error("LEN_W too narrow for fixed burst lengths");
      end
      if (FILL_WORDS < 1 || EVICT_SHORT < 1 || EVICT_LONG < 1) begin : g_bad_fixed
         $error("fixed burst lengths must be at least one word");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("ADDR_W too small");
      end
   endgenerate

   seq_state_e       state;
   logic             load, step, last;
   logic [1:0]       cls_burst;
   logic             cls_write, cls_more_en;
   logic [LEN_W-1:0] cls_words;
   logic [1:0]       burst_q;
   logic             write_q, more_en_q;
   logic             seq_active;

   bxs_classify #(
      .LEN_W(LEN_W), .FILL_WORDS(FILL_WORDS),
      .EVICT_SHORT(EVICT_SHORT), .EVICT_LONG(EVICT_LONG)
   ) u_classify (
      .kind_i(req_kind), .len_i(req_len),
      .burst_o(cls_burst), .write_o(cls_write),
      .more_en_o(cls_more_en), .words_o(cls_words)
   );

   bxs_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid_i(req_valid), .grant_i(bus_grant), .wait_i(bus_wait),
      .last_i(last), .state_o(state), .load_o(load), .step_o(step)
   );

   bxs_walker #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W),
      .WORD_BYTES(WORD_BYTES), .ALIGN_ADDR(ALIGN_ADDR)
   ) u_walker (
      .clk(clk), .rst_n(rst_n),
      .load_i(load), .addr_i(req_addr), .words_i(cls_words),
      .step_i(step), .addr_o(bus_addr), .last_o(last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         burst_q   <= BH_NONE;
         write_q   <= 1'b0;
         more_en_q <= 1'b0;
      end else if (load) begin
         burst_q   <= cls_burst;
         write_q   <= cls_write;
         more_en_q <= cls_more_en;
      end
   end

   assign seq_active  = (state == ST_SEQ) && bus_grant;
   assign bus_trans   = seq_active ? TT_SEQ : TT_ADDR;
   assign bus_astrobe = (state == ST_OPEN) && bus_grant;
   assign bus_burst   = burst_q;
   assign bus_write   = write_q;
   assign bus_more    = seq_active && more_en_q && !last;
   assign req_ready   = (state == ST_IDLE);
   assign req_done    = step && last;
endmodule

// File: rtl/bus_xfer_seq_chk.sv
module bus_xfer_seq_chk #(
   parameter int ADDR_W     = 32,
   parameter int WORD_BYTES = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_grant,
   input logic              bus_wait,
   input logic [1:0]        bus_trans,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_astrobe,
   input logic [1:0]        bus_burst,
   input logic              bus_more,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_done
);
   assert_no_nonseq_R1: assert property (@(posedge clk) disable iff (!rst_n)
      bus_trans != 2'b10);

   assert_idle_when_ungranted_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_grant |-> bus_trans == 2'b00);

   assert_strobe_on_addr_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_astrobe |-> (bus_trans == 2'b00 && bus_grant && !req_ready));

   assert_strobe_then_seq_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_astrobe |=> (bus_grant -> bus_trans == 2'b11));

   assert_hint_hold_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |=> (!req_ready -> $stable(bus_burst)));

   assert_hint_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && !req_valid) |=> $stable(bus_burst));

   assert_more_in_seq_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_more |-> bus_trans == 2'b11);

   assert_addr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_trans == 2'b11 && !bus_wait && !req_done)
      |=> bus_addr == $past(bus_addr) + ADDR_W'(WORD_BYTES));

   assert_wait_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_trans == 2'b11 && bus_wait) |=> ($stable(bus_addr) && !req_ready));

   assert_grant_loss_reopens_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && !bus_astrobe && !bus_grant) |=> (!req_ready && bus_trans != 2'b11 || bus_grant));

   assert_done_completes_R11: assert property (@(posedge clk) disable iff (!rst_n)
      req_done |-> (bus_trans == 2'b11 && !bus_wait));

   assert_done_frees_R11: assert property (@(posedge clk) disable iff (!rst_n)
      req_done |=> req_ready);
endmodule

bind bus_xfer_seq bus_xfer_seq_chk #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_grant(bus_grant), .bus_wait(bus_wait),
   .bus_trans(bus_trans), .bus_addr(bus_addr), .bus_astrobe(bus_astrobe),
   .bus_burst(bus_burst), .bus_more(bus_more), .req_valid(req_valid),
   .req_ready(req_ready), .req_done(req_done)
);

// File: tb/bus_xfer_seq_bench.sv
module bus_xfer_seq_bench;
   localparam int AW = 16;
   localparam int LW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [2:0]    req_kind = '0;
   logic [AW-1:0] req_addr = '0;
   logic [LW-1:0] req_len = '0;
   logic          req_ready, req_done;
   logic          bus_grant = 1'b0;
   logic          bus_wait = 1'b0;
   logic [1:0]    bus_trans;
   logic [AW-1:0] bus_addr;
   logic          bus_write, bus_astrobe, bus_more;
   logic [1:0]    bus_burst;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   bus_xfer_seq #(.ADDR_W(AW), .LEN_W(LW)) u_bus_xfer_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
      .req_len(req_len), .req_ready(req_ready), .req_done(req_done),
      .bus_grant(bus_grant), .bus_wait(bus_wait), .bus_trans(bus_trans),
      .bus_addr(bus_addr), .bus_write(bus_write), .bus_astrobe(bus_astrobe),
      .bus_burst(bus_burst), .bus_more(bus_more)
   );

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic int exp_hint(int k);
      case (k)
         2, 3: return 3;
         4, 6: return 2;
         5:    return 1;
         default: return 0;
      endcase
   endfunction

   function automatic int exp_wr(int k);
      return (k == 1 || k == 2 || k == 5 || k == 6) ? 1 : 0;
   endfunction

   function automatic int exp_words(int k, int len);
      case (k)
         3: return 1;
         4: return 8;
         5: return 4;
         6: return 8;
         default: return (len == 0) ? 1 : len;
      endcase
   endfunction

   task automatic run_xfer(int kind, int addr, int len, bit waits, bit drop);
      int n      = exp_words(kind, len);
      int hint   = exp_hint(kind);
      int wr     = exp_wr(kind);
      int base   = addr & 'hFFFC;
      int more_k = (kind == 0 || kind == 7) ? 1 : 0;
      int drop_w = (n > 1) ? 1 : 0;
      int w      = 0;
      int waited = -1;
      bit dropped = 1'b0;
      bit open   = 1'b0;

      @(negedge clk);
      req_valid = 1'b1; req_kind = 3'(kind); req_addr = AW'(addr); req_len = LW'(len);
      bus_grant = 1'b1; bus_wait = 1'b0;
      #1 chk("R11 ready before accept", int'(req_ready), 1);
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      chk("R4 burst hint", int'(bus_burst), hint);
      chk("R4 write flag", int'(bus_write), wr);
      chk("R1 opening type", int'(bus_trans), 0);
      chk("R2 opening strobe", int'(bus_astrobe), 1);
      chk("R11 busy", int'(req_ready), 0);

      while (w < n) begin
         @(negedge clk);
         if (open) begin
            bus_grant = 1'b1; bus_wait = 1'b0;
            #1;
            chk("R10 reopen strobe", int'(bus_astrobe), 1);
            chk("R10 reopen type", int'(bus_trans), 0);
            chk("R10 reopen addr", int'(bus_addr), (base + 4 * w) & 'hFFFF);
            open = 1'b0;
         end else if (drop && !dropped && w == drop_w) begin
            bus_grant = 1'b0; bus_wait = 1'b0;
            #1;
            chk("R10 lost grant type", int'(bus_trans), 0);
            chk("R10 lost grant done", int'(req_done), 0);
            chk("R7 lost grant more", int'(bus_more), 0);
            @(negedge clk);
            #1;
            chk("R2 ungranted open strobe", int'(bus_astrobe), 0);
            chk("R3 stays opening", int'(bus_trans), 0);
            dropped = 1'b1;
            open = 1'b1;
         end else begin
            bit wt = waits && (w % 2 == 0) && (waited != w);
            if (wt) waited = w;
            bus_grant = 1'b1; bus_wait = wt;
            #1;
            chk("R1 R3 sequential type", int'(bus_trans), 3);
            chk("R2 no strobe in seq", int'(bus_astrobe), 0);
            chk("R8 R9 word addr", int'(bus_addr), (base + 4 * w) & 'hFFFF);
            chk("R7 more flag", int'(bus_more), (more_k != 0 && w < n - 1) ? 1 : 0);
            chk("R11 done", int'(req_done), (!wt && w == n - 1) ? 1 : 0);
            chk("R6 hint held", int'(bus_burst), hint);
            if (!wt) w++;
         end
      end
      @(negedge clk);
      bus_wait = 1'b0;
      #1;
      chk("R5 ready after word count", int'(req_ready), 1);
      chk("R1 idle type", int'(bus_trans), 0);
      chk("R2 idle strobe", int'(bus_astrobe), 0);
      chk("R6 hint after done", int'(bus_burst), hint);
      chk("R6 write after done", int'(bus_write), wr);
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R11 reset ready", int'(req_ready), 1);
      chk("R1 reset type", int'(bus_trans), 0);
      chk("R2 reset strobe", int'(bus_astrobe), 0);
      chk("R6 reset hint", int'(bus_burst), 0);
      chk("R7 reset more", int'(bus_more), 0);
      chk("R11 reset done", int'(req_done), 0);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         bus_grant = i[0];
         #1;
         chk("R2 idle strobe with grant toggling", int'(bus_astrobe), 0);
         chk("R1 idle type with grant toggling", int'(bus_trans), 0);
      end
      for (int k = 0; k < 8; k++) begin
         for (int li = 0; li < 4; li++) begin
            for (int p = 0; p < 4; p++) begin
               int len = (li == 0) ? 0 : (li == 1) ? 1 : (li == 2) ? 3 : 5;
               int addr = 'h0100 + k * 'h40 + len * 4 + p;
               run_xfer(k, addr, len, p[0], p[1]);
            end
         end
      end
      run_xfer(4, 'hFFF3, 0, 1'b0, 1'b0);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule